// File: doc/BRIEF.md
# RS-485 Transceiver Enable and Fault Logic

This block is the digital control layer of an isolated differential-bus transceiver. Its inputs are the driver enable, the receiver enable, the transmit bit, a two-bit code from the analog window comparators on the receive pair, two supply-good flags (logic side and bus side) and a signed die temperature in whole degrees Celsius. Its outputs are the levels and per-line output enables for the non-inverting and inverting driver pins. It also produces the receive data bit with its own output enable, and a registered thermal shutdown flag.

Receive decoding is fail-safe. Both comparator thresholds lie below zero, so an idle bus that has decayed to 0 V reads high. An open or shorted input also reads high. The indeterminate band between the two thresholds holds the last decoded level. When a supply is lost, the driver is forced off and the receive bit takes a fixed default. The thermal flag sets at the upper temperature limit and clears only at the lower one. It turns off the driver alone and leaves the receive path running.

Top module: `rs485_ctl`

## Requirements
- R1: While `drv_en` is 0, `y_oe` and `z_oe` are both 0, whatever the other inputs are.
- R2: While `drv_en` is 1, both supply flags are 1 and `therm_shut` is 0, `y_oe` and `z_oe` are 1, `y_out` equals `tx_data` and `z_out` equals its complement.
- R3: `rx_oe` is 1 exactly while `rcv_en_n` is 0.
- R4: With both supplies good, `diff_code` 2'b01 (difference above the upper, less negative threshold) gives `rx_out` 1, and `diff_code` 2'b10 (difference below the lower threshold) gives `rx_out` 0.
- R5: With both supplies good, `diff_code` 2'b00 (between the thresholds) makes `rx_out` repeat the `rx_out` level that was present at the previous rising clock edge. That level is 1 after reset.
- R6: With both supplies good, `diff_code` 2'b11 (open or shorted input) gives `rx_out` 1.
- R7: `therm_shut` is 0 after reset. At a rising edge it becomes 1 if `die_temp` is at least `HOT_C` (150). It becomes 0 if `die_temp` is at most `COOL_C` (140). Otherwise it keeps its value.
- R8: While `therm_shut` is 1, `y_oe` and `z_oe` are 0.
- R9: While either supply flag is 0, `y_oe` and `z_oe` are 0.
- R10: With the logic supply good and the bus supply lost, `rx_out` is 1. With the logic supply lost, `rx_out` is 0.
- R11: `therm_shut` has no effect on `rx_out` or `rx_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the thermal flag and the receive hold register |
| rst_n | input | 1 | Active-low synchronous reset |
| drv_en | input | 1 | Driver enable, active high |
| rcv_en_n | input | 1 | Receiver enable, active low |
| tx_data | input | 1 | Bit to transmit |
| diff_code | input | 2 | Window comparator code: 00 between, 01 high, 10 low, 11 open |
| logic_pwr_ok | input | 1 | Logic-side supply good |
| bus_pwr_ok | input | 1 | Bus-side supply good |
| die_temp | input | TEMP_W (9) | Signed die temperature in degrees Celsius |
| y_out | output | 1 | Non-inverting driver level (0 while not driving) |
| z_out | output | 1 | Inverting driver level (0 while not driving) |
| y_oe | output | 1 | Output enable of the non-inverting line |
| z_oe | output | 1 | Output enable of the inverting line |
| rx_out | output | 1 | Decoded receive level |
| rx_oe | output | 1 | Output enable of the receive bit |
| therm_shut | output | 1 | Registered thermal shutdown flag |

## Verification
The assertions assume that the inputs are steady around each rising edge. They also assume that `die_temp` is a valid two's complement value. The stimulus changes every input on the falling edge, and the temperature follows a triangle from -40 to 170 in steps of one degree, so every value near both limits is visited from both directions. The assertions assume nothing about the order of comparator codes. The bench therefore walks a permutation of all 128 control combinations, so that the indeterminate code follows each possible earlier level and each supply state.

// File: rtl/rs485_ctl_pkg.sv
package rs485_ctl_pkg;

  typedef enum logic [1:0] {
    DIFF_MID  = 2'b00,
    DIFF_HIGH = 2'b01,
    DIFF_LOW  = 2'b10,
    DIFF_OPEN = 2'b11
  } diff_code_e;

  // Level seen on the receive bit for a comparator code with both supplies good.
  function automatic logic window_level(input logic [1:0] code, input logic held);
    logic lvl;
    case (code)
      DIFF_HIGH: lvl = 1'b1;
      DIFF_LOW:  lvl = 1'b0;
      DIFF_OPEN: lvl = 1'b1;
      default:   lvl = held;
    endcase
    return lvl;
  endfunction

  // Supply-aware receive level: logic side lost reads low, bus side lost reads high.
  function automatic logic rx_level(input logic lg_ok, input logic bs_ok,
                                    input logic [1:0] code, input logic held);
    logic lvl;
    if (!lg_ok)      lvl = 1'b0;
    else if (!bs_ok) lvl = 1'b1;
    else             lvl = window_level(code, held);
    return lvl;
  endfunction

  // Hysteretic thermal flag update.
  function automatic logic thermal_next(input logic cur, input int temp_c,
                                        input int hot_c, input int cool_c);
    logic nxt;
    if (temp_c >= hot_c)       nxt = 1'b1;
    else if (temp_c <= cool_c) nxt = 1'b0;
    else                       nxt = cur;
    return nxt;
  endfunction

endpackage

// File: rtl/rs485_thermal_guard.sv
module rs485_thermal_guard
  import rs485_ctl_pkg::*;
#(
  parameter int TEMP_W = 9,
  parameter int HOT_C  = 150,
  parameter int COOL_C = 140
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [TEMP_W-1:0] die_temp,
  output logic                     shut
);

  logic shut_q;
  logic shut_d;
  int   temp_int;

  always_comb begin
    temp_int = int'(die_temp);
    shut_d   = thermal_next(shut_q, temp_int, HOT_C, COOL_C);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) shut_q <= 1'b0;
    else        shut_q <= shut_d;
  end

  assign shut = shut_q;

endmodule

// File: rtl/rs485_rx_path.sv
module rs485_rx_path
  import rs485_ctl_pkg::*;
#(
  parameter bit MID_HOLD = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rcv_en_n,
  input  logic [1:0] diff_code,
  input  logic       logic_ok,
  input  logic       bus_ok,
  output logic       rx_bit,
  output logic       rx_en
);

  logic held_q;
  logic level;

  generate
    if (MID_HOLD) begin : g_hold
      always_comb level = rx_level(logic_ok, bus_ok, diff_code, held_q);
    end else begin : g_force_high
      always_comb level = rx_level(logic_ok, bus_ok, diff_code, 1'b1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) held_q <= 1'b1;
    else        held_q <= level;
  end

  assign rx_bit = level;
  assign rx_en  = ~rcv_en_n;

endmodule

// File: rtl/rs485_tx_stage.sv
module rs485_tx_stage (
  input  logic drv_en,
  input  logic tx_data,
  input  logic logic_ok,
  input  logic bus_ok,
  input  logic shut,
  output logic y_lvl,
  output logic z_lvl,
  output logic y_en,
  output logic z_en
);

  logic supplies_up;
  logic drive_now;

  assign supplies_up = logic_ok & bus_ok;
  assign drive_now   = drv_en & supplies_up & ~shut;

  assign y_lvl = drive_now & tx_data;
  assign z_lvl = drive_now & ~tx_data;
  assign y_en  = drive_now;
  assign z_en  = drive_now;

endmodule

// File: rtl/rs485_ctl.sv
module rs485_ctl #(
  parameter int TEMP_W   = 9,
  parameter int HOT_C    = 150,
  parameter int COOL_C   = 140,
  parameter bit MID_HOLD = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     drv_en,
  input  logic                     rcv_en_n,
  input  logic                     tx_data,
  input  logic [1:0]               diff_code,
  input  logic                     logic_pwr_ok,
  input  logic                     bus_pwr_ok,
  input  logic signed [TEMP_W-1:0] die_temp,
  output logic                     y_out,
  output logic                     z_out,
  output logic                     y_oe,
  output logic                     z_oe,
  output logic                     rx_out,
  output logic                     rx_oe,
  output logic                     therm_shut
);

  logic shut_w;

  rs485_thermal_guard #(
    .TEMP_W (TEMP_W),
    .HOT_C  (HOT_C),
    .COOL_C (COOL_C)
  ) u_thermal (
    .clk      (clk),
    .rst_n    (rst_n),
    .die_temp (die_temp),
    .shut     (shut_w)
  );

  rs485_tx_stage u_tx (
    .drv_en   (drv_en),
    .tx_data  (tx_data),
    .logic_ok (logic_pwr_ok),
    .bus_ok   (bus_pwr_ok),
    .shut     (shut_w),
    .y_lvl    (y_out),
    .z_lvl    (z_out),
    .y_en     (y_oe),
    .z_en     (z_oe)
  );

  rs485_rx_path #(
    .MID_HOLD (MID_HOLD)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .rcv_en_n  (rcv_en_n),
    .diff_code (diff_code),
    .logic_ok  (logic_pwr_ok),
    .bus_ok    (bus_pwr_ok),
    .rx_bit    (rx_out),
    .rx_en     (rx_oe)
  );

  assign therm_shut = shut_w;

endmodule

// File: rtl/rs485_ctl_chk.sv
module rs485_ctl_chk #(
  parameter int TEMP_W = 9,
  parameter int HOT_C  = 150,
  parameter int COOL_C = 140
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     drv_en,
  input logic                     rcv_en_n,
  input logic [1:0]               diff_code,
  input logic                     logic_pwr_ok,
  input logic                     bus_pwr_ok,
  input logic signed [TEMP_W-1:0] die_temp,
  input logic                     y_out,
  input logic                     z_out,
  input logic                     y_oe,
  input logic                     z_oe,
  input logic                     rx_out,
  input logic                     rx_oe,
  input logic                     therm_shut
);

  assert_drv_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> (!y_oe && !z_oe));

  assert_diff_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    y_oe |-> (y_out != z_out));

  assert_rx_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_oe == !rcv_en_n);

  assert_open_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (logic_pwr_ok && bus_pwr_ok && diff_code == 2'b11) |-> rx_out);

  assert_therm_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(die_temp) >= HOT_C) |=> therm_shut);

  assert_therm_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_shut && int'(die_temp) > COOL_C) |=> therm_shut);

  assert_therm_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!therm_shut && int'(die_temp) < HOT_C) |=> !therm_shut);

  assert_therm_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    therm_shut |-> (!y_oe && !z_oe));

  assert_supply_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(logic_pwr_ok && bus_pwr_ok) |-> (!y_oe && !z_oe));

  assert_bus_loss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (logic_pwr_ok && !bus_pwr_ok) |-> rx_out);

  assert_logic_loss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !logic_pwr_ok |-> !rx_out);

endmodule

bind rs485_ctl rs485_ctl_chk #(
  .TEMP_W (TEMP_W),
  .HOT_C  (HOT_C),
  .COOL_C (COOL_C)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .drv_en       (drv_en),
  .rcv_en_n     (rcv_en_n),
  .diff_code    (diff_code),
  .logic_pwr_ok (logic_pwr_ok),
  .bus_pwr_ok   (bus_pwr_ok),
  .die_temp     (die_temp),
  .y_out        (y_out),
  .z_out        (z_out),
  .y_oe         (y_oe),
  .z_oe         (z_oe),
  .rx_out       (rx_out),
  .rx_oe        (rx_oe),
  .therm_shut   (therm_shut)
);

// File: tb/rs485_ctl_bench.sv
`timescale 1ns/1ps
module rs485_ctl_bench;

  localparam int TW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drv_en = 1'b0;
  logic rcv_en_n = 1'b1;
  logic tx_data = 1'b0;
  logic [1:0] diff_code = 2'b00;
  logic logic_pwr_ok = 1'b1;
  logic bus_pwr_ok = 1'b1;
  logic signed [TW-1:0] die_temp = 9'sd25;
  logic y_out, z_out, y_oe, z_oe, rx_out, rx_oe, therm_shut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench-side model state
  logic m_hot;
  logic m_prev;

  always #2 clk = ~clk;

  rs485_ctl u_rs485_ctl (
    .clk (clk), .rst_n (rst_n), .drv_en (drv_en), .rcv_en_n (rcv_en_n),
    .tx_data (tx_data), .diff_code (diff_code), .logic_pwr_ok (logic_pwr_ok),
    .bus_pwr_ok (bus_pwr_ok), .die_temp (die_temp), .y_out (y_out),
    .z_out (z_out), .y_oe (y_oe), .z_oe (z_oe), .rx_out (rx_out),
    .rx_oe (rx_oe), .therm_shut (therm_shut)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b temp=%0d", tag, what, act, exp, die_temp);
    end
  endtask

  // receive level restated as a priority of cases
  function automatic logic exp_rx(input logic lg, input logic bs, input logic [1:0] c,
                                  input logic prev);
    if (lg == 1'b0) return 1'b0;
    if (bs == 1'b0) return 1'b1;
    if (c == 2'b10) return 1'b0;
    if (c == 2'b00) return prev;
    return 1'b1;
  endfunction

  function automatic int tri_temp(input int k);
    int p;
    p = k % 420;
    return (p < 210) ? (p - 40) : (170 - (p - 210));
  endfunction

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
      $finish;
    end
  end

  initial begin
    logic e_drive, e_rx, e_y;
    string rx_tag, oe_tag;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // reset state
    chk("R7", "therm_shut in reset", therm_shut, 1'b0);
    chk("R5", "rx_out mid code in reset", rx_out, 1'b1);
    chk("R3", "rx_oe disabled", rx_oe, 1'b0);
    chk("R1", "y_oe disabled", y_oe, 1'b0);
    rst_n = 1'b1;
    m_hot  = 1'b0;
    m_prev = 1'b1;
    @(posedge clk);
    for (int k = 0; k < 1500; k++) begin
      int idx;
      @(negedge clk);
      idx = (k * 37 + 5) % 128;
      drv_en       = idx[0];
      rcv_en_n     = idx[1];
      tx_data      = idx[2];
      diff_code    = idx[4:3];
      logic_pwr_ok = idx[5];
      bus_pwr_ok   = idx[6];
      die_temp     = TW'(tri_temp(k));
      #1;
      e_drive = drv_en && logic_pwr_ok && bus_pwr_ok && !m_hot;
      e_rx    = exp_rx(logic_pwr_ok, bus_pwr_ok, diff_code, m_prev);
      if (!drv_en)                          oe_tag = "R1";
      else if (!(logic_pwr_ok && bus_pwr_ok)) oe_tag = "R9";
      else if (m_hot)                       oe_tag = "R8";
      else                                  oe_tag = "R2";
      chk(oe_tag, "y_oe", y_oe, e_drive);
      chk(oe_tag, "z_oe", z_oe, e_drive);
      if (e_drive) begin
        e_y = tx_data;
        chk("R2", "y_out", y_out, e_y);
        chk("R2", "z_out", z_out, !e_y);
      end
      chk("R3", "rx_oe", rx_oe, !rcv_en_n);
      if (!(logic_pwr_ok && bus_pwr_ok)) rx_tag = "R10";
      else if (diff_code == 2'b00)      rx_tag = "R5";
      else if (diff_code == 2'b11)      rx_tag = "R6";
      else                              rx_tag = "R4";
      chk(rx_tag, "rx_out", rx_out, e_rx);
      if (m_hot) begin
        chk("R11", "rx_out during shutdown", rx_out, e_rx);
        chk("R11", "rx_oe during shutdown", rx_oe, !rcv_en_n);
      end
      chk("R7", "therm_shut", therm_shut, m_hot);
      @(posedge clk);
      if (int'(die_temp) > 149)      m_hot = 1'b1;
      else if (int'(die_temp) < 141) m_hot = 1'b0;
      m_prev = e_rx;
    end
    done = 1'b1;
    report();
    $finish;
  end

endmodule